// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a multi-ported register file for a processor whose procedures each see 32 logical registers. Behind those 32 names sit 74 physical 32-bit registers. Ten of them are global and are visible from every procedure. The other 64 form a ring of four windows. Each window owns 10 private locals and 6 shared common registers.

A current window pointer (CWP) chooses which slice of the ring the logical names 10 to 31 reach. The six outgoing registers of a caller are physically the same storage as the six incoming registers of the callee. Arguments and results therefore pass between the two without any copy.

A call strobe advances the pointer by one and a return strobe moves it back by one. A small depth counter tracks nested calls. It raises a one-cycle overflow pulse when the ring would need spilling, and a one-cycle underflow pulse when there is nothing left to return to. Spilling windows to memory is left to the surrounding core.

Top module: `rwin_regfile`

## Requirements
- R1: While reset is asserted and after it is released, the pointer `cwp_o` reads 0 and both `ovf_o` and `unf_o` read 0.
- R2: Logical addresses 0 to 9 reach the same 10 global registers whatever the pointer is. A value written there is read back unchanged after any number of calls or returns.
- R3: A logical address n from 10 to 31 reaches physical register 10 + ((16·CWP + n − 10) mod 64). Both read ports and the write port use the pointer value held in the current cycle.
- R4: After a call, the callee's logical registers 10 to 15 return what the caller wrote to its logical registers 26 to 31, in the same order. This includes the wrap from window 3 to window 0.
- R5: A write to logical locals 16 to 25 in one window does not change the locals of any other window.
- R6: A cycle with `call_i`=1 and `ret_i`=0 makes `cwp_o` step up by one modulo 4 on the next clock edge. A cycle with `ret_i`=1 and `call_i`=0 makes it step down by one modulo 4.
- R7: A cycle with both `call_i` and `ret_i` high behaves as if neither were high. The pointer and the depth count stay put and no flag is raised.
- R8: Reads are combinational and writes land on the clock edge. A read of the register being written in that same cycle returns the old contents. The new value is visible from the next cycle on.
- R9: With `wr_en`=0, no register changes, whatever `wr_addr` and `wr_data` carry.
- R10: A call made while 3 calls are outstanding drives `ovf_o` high for exactly the cycle after that edge. The pointer still advances and the outstanding count stays at 3.
- R11: A return made with no calls outstanding drives `unf_o` high for exactly the cycle after that edge. The pointer still steps back and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| call_i | input | 1 | Procedure call strobe, one per cycle |
| ret_i | input | 1 | Procedure return strobe, one per cycle |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical write address |
| wr_data | input | 32 | Write data |
| rd_addr_a | input | 5 | Logical address of read port A |
| rd_data_a | output | 32 | Read port A data, combinational |
| rd_addr_b | input | 5 | Logical address of read port B |
| rd_data_b | output | 32 | Read port B data, combinational |
| cwp_o | output | 2 | Current window pointer |
| ovf_o | output | 1 | Window overflow pulse |
| unf_o | output | 1 | Window underflow pulse |

## Verification
The properties assume that every input is a known level on each clock edge after reset and that a strobe is held for the whole cycle it applies to. The forwarding checks also assume that read port A is fed a fresh address each cycle, not a glitching one. The bench drives all inputs on the falling edge and never leaves them undriven. It keeps calls and returns sparse but random, so the outstanding count reaches both the bottom and the top of its range many times. Directed sequences place a strobe exactly at depth 0 and depth 3, and place both strobes in the same cycle.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  // Decoded window event for one cycle
  typedef enum logic [1:0] {
    WEV_NONE = 2'd0,
    WEV_CALL = 2'd1,
    WEV_RET  = 2'd2
  } win_evt_e;

  // Simultaneous call and return cancel each other
  function automatic win_evt_e classify_evt(input logic call, input logic ret);
    win_evt_e evt;
    if (call && !ret)      evt = WEV_CALL;
    else if (ret && !call) evt = WEV_RET;
    else                   evt = WEV_NONE;
    return evt;
  endfunction

endpackage

// File: rtl/rwf_window_ctl.sv
module rwf_window_ctl #(
  parameter  int NUM_WIN = 4,
  localparam int CWP_W   = $clog2(NUM_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  import rwf_pkg::*;

  localparam logic [CWP_W-1:0] CWP_MAX = CWP_W'(NUM_WIN - 1);

  win_evt_e         evt;
  logic [CWP_W-1:0] cwp_q, cwp_d;
  logic [CWP_W-1:0] depth_q, depth_d;
  logic             ovf_q, ovf_d;
  logic             unf_q, unf_d;
  logic             state_en;

  // next-state logic
  always_comb begin
    evt      = classify_evt(call_i, ret_i);
    cwp_d    = cwp_q;
    depth_d  = depth_q;
    ovf_d    = 1'b0;
    unf_d    = 1'b0;
    state_en = 1'b0;
    case (evt)
      WEV_CALL: begin
        state_en = 1'b1;
        cwp_d    = (cwp_q == CWP_MAX) ? '0 : cwp_q + 1'b1;
        if (depth_q == CWP_MAX) ovf_d   = 1'b1;
        else                    depth_d = depth_q + 1'b1;
      end
      WEV_RET: begin
        state_en = 1'b1;
        cwp_d    = (cwp_q == '0) ? CWP_MAX : cwp_q - 1'b1;
        if (depth_q == '0) unf_d   = 1'b1;
        else               depth_d = depth_q - 1'b1;
      end
      default: begin
        state_en = 1'b0;
      end
    endcase
  end

  // pointer and depth registers, enabled on a real event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      depth_q <= '0;
    end else if (state_en) begin
      cwp_q   <= cwp_d;
      depth_q <= depth_d;
    end
  end

  // single-cycle flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

endmodule

// File: rtl/rwf_addr_map.sv
module rwf_addr_map #(
  parameter  int NUM_GLOBAL = 10,
  parameter  int NUM_LOCAL  = 10,
  parameter  int NUM_COMMON = 6,
  parameter  int NUM_WIN    = 4,
  localparam int LOG_REGS   = NUM_GLOBAL + NUM_LOCAL + 2 * NUM_COMMON,
  localparam int LOG_W      = $clog2(LOG_REGS),
  localparam int STRIDE     = NUM_LOCAL + NUM_COMMON,
  localparam int RING       = STRIDE * NUM_WIN,
  localparam int NUM_PHYS   = RING + NUM_GLOBAL,
  localparam int PHYS_W     = $clog2(NUM_PHYS),
  localparam int CWP_W      = $clog2(NUM_WIN)
) (
  input  logic [LOG_W-1:0]  log_addr,
  input  logic [CWP_W-1:0]  cwp,
  output logic [PHYS_W-1:0] phys_addr
);
  localparam int OFF_W = $clog2(2 * RING);

  logic [OFF_W-1:0] off_raw;
  logic [OFF_W-1:0] off_wrap;
  logic             is_global;

  // window base plus offset, folded once into the ring
  always_comb begin
    is_global = (log_addr < LOG_W'(NUM_GLOBAL));
    off_raw   = OFF_W'(STRIDE) * OFF_W'(cwp) + OFF_W'(log_addr) - OFF_W'(NUM_GLOBAL);
    off_wrap  = (off_raw >= OFF_W'(RING)) ? off_raw - OFF_W'(RING) : off_raw;
    if (is_global) phys_addr = PHYS_W'(log_addr);
    else           phys_addr = PHYS_W'(NUM_GLOBAL) + PHYS_W'(off_wrap);
  end

endmodule

// File: rtl/rwf_storage.sv
module rwf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_PHYS = 74,
  parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PHYS_W-1:0] rd_phys_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [PHYS_W-1:0] rd_phys_b,
  output logic [DATA_W-1:0] rd_data_b
);
  logic [DATA_W-1:0]   regs_q [NUM_PHYS];
  logic [NUM_PHYS-1:0] row_we;

  // write decoder
  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_dec
    assign row_we[g] = wr_en && (wr_phys == PHYS_W'(g));
  end

  // datapath storage, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (row_we[i]) regs_q[i] <= wr_data;
    end
  end

  // combinational reads
  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    if (rd_phys_a < PHYS_W'(NUM_PHYS)) rd_data_a = regs_q[rd_phys_a];
    if (rd_phys_b < PHYS_W'(NUM_PHYS)) rd_data_b = regs_q[rd_phys_b];
  end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter  int DATA_W     = 32,
  parameter  int NUM_GLOBAL = 10,
  parameter  int NUM_LOCAL  = 10,
  parameter  int NUM_COMMON = 6,
  parameter  int NUM_WIN    = 4,
  localparam int LOG_REGS   = NUM_GLOBAL + NUM_LOCAL + 2 * NUM_COMMON,
  localparam int LOG_W      = $clog2(LOG_REGS),
  localparam int NUM_PHYS   = (NUM_LOCAL + NUM_COMMON) * NUM_WIN + NUM_GLOBAL,
  localparam int PHYS_W     = $clog2(NUM_PHYS),
  localparam int CWP_W      = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              wr_en,
  input  logic [LOG_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LOG_W-1:0]  rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [LOG_W-1:0]  rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [CWP_W-1:0]  cwp_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int NUM_PORTS = 3;  // write, read A, read B

  logic [CWP_W-1:0]  cwp;
  logic [LOG_W-1:0]  map_log  [NUM_PORTS];
  logic [PHYS_W-1:0] map_phys [NUM_PORTS];

  rwf_window_ctl #(
    .NUM_WIN (NUM_WIN)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .call_i (call_i),
    .ret_i  (ret_i),
    .cwp_o  (cwp),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  assign map_log[0] = wr_addr;
  assign map_log[1] = rd_addr_a;
  assign map_log[2] = rd_addr_b;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    rwf_addr_map #(
      .NUM_GLOBAL (NUM_GLOBAL),
      .NUM_LOCAL  (NUM_LOCAL),
      .NUM_COMMON (NUM_COMMON),
      .NUM_WIN    (NUM_WIN)
    ) u_map (
      .log_addr  (map_log[p]),
      .cwp       (cwp),
      .phys_addr (map_phys[p])
    );
  end

  rwf_storage #(
    .DATA_W   (DATA_W),
    .NUM_PHYS (NUM_PHYS),
    .PHYS_W   (PHYS_W)
  ) u_store (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_phys   (map_phys[0]),
    .wr_data   (wr_data),
    .rd_phys_a (map_phys[1]),
    .rd_data_a (rd_data_a),
    .rd_phys_b (map_phys[2]),
    .rd_data_b (rd_data_b)
  );

  assign cwp_o = cwp;

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter  int DATA_W     = 32,
  parameter  int NUM_GLOBAL = 10,
  parameter  int NUM_LOCAL  = 10,
  parameter  int NUM_COMMON = 6,
  parameter  int NUM_WIN    = 4,
  localparam int LOG_W      = $clog2(NUM_GLOBAL + NUM_LOCAL + 2 * NUM_COMMON),
  localparam int CWP_W      = $clog2(NUM_WIN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic              wr_en,
  input logic [LOG_W-1:0]  wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [LOG_W-1:0]  rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [CWP_W-1:0]  cwp_o,
  input logic              ovf_o,
  input logic              unf_o
);
  localparam logic [CWP_W-1:0] CWP_TOP  = CWP_W'(NUM_WIN - 1);
  localparam logic [LOG_W-1:0] OUT_BASE = LOG_W'(NUM_GLOBAL + NUM_LOCAL + NUM_COMMON);
  localparam logic [LOG_W-1:0] SHIFT    = LOG_W'(NUM_LOCAL + NUM_COMMON);

  AST_CWP_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i) |=> (cwp_o == (($past(cwp_o) == CWP_TOP) ? '0 : $past(cwp_o) + 1'b1))); // R6

  AST_CWP_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=> (cwp_o == (($past(cwp_o) == '0) ? CWP_TOP : $past(cwp_o) - 1'b1))); // R6

  AST_CWP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i == ret_i) |=> $stable(cwp_o)); // R7

  AST_OVF_NEEDS_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(call_i && !ret_i)); // R10

  AST_UNF_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> $past(ret_i && !call_i)); // R11

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o)); // R10

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (call_i == ret_i)) |=>
      ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data)))); // R8

  AST_GLOBAL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < LOG_W'(NUM_GLOBAL))) |=>
      ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data)))); // R2

  AST_OUTGOING_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && call_i && !ret_i && (wr_addr >= OUT_BASE)) |=>
      ((rd_addr_a != ($past(wr_addr) - SHIFT)) || (rd_data_a == $past(wr_data)))); // R4

endmodule

bind rwin_regfile rwin_regfile_chk #(
  .DATA_W     (DATA_W),
  .NUM_GLOBAL (NUM_GLOBAL),
  .NUM_LOCAL  (NUM_LOCAL),
  .NUM_COMMON (NUM_COMMON),
  .NUM_WIN    (NUM_WIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .cwp_o     (cwp_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o)
);

// File: tb/tb_rwin_regfile.sv
`timescale 1ns/1ps
module tb_rwin_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call = 1'b0, ret = 1'b0, wen = 1'b0;
  logic [4:0]  waddr = '0, ra = '0, rb = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rda, rdb;
  logic [1:0]  cwp;
  logic        ovf, unf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  logic [31:0] m_regs  [74];
  bit          m_valid [74];
  int          m_cwp, m_depth;
  bit          m_ovf, m_unf;

  always #5 clk = ~clk;

  rwin_regfile dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_i    (call),
    .ret_i     (ret),
    .wr_en     (wen),
    .wr_addr   (waddr),
    .wr_data   (wdata),
    .rd_addr_a (ra),
    .rd_data_a (rda),
    .rd_addr_b (rb),
    .rd_data_b (rdb),
    .cwp_o     (cwp),
    .ovf_o     (ovf),
    .unf_o     (unf)
  );

  // expected physical index for a logical name
  function automatic int lmap(int n, int c);
    if (n < 10) return n;
    return 10 + ((16 * c + n - 10) % 64);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cwp = 0; m_depth = 0; m_ovf = 0; m_unf = 0;
    end else begin
      if (wen) begin
        m_regs[lmap(int'(waddr), m_cwp)]  = wdata;
        m_valid[lmap(int'(waddr), m_cwp)] = 1;
      end
      m_ovf = 0; m_unf = 0;
      if (call && !ret) begin
        if (m_depth == 3) m_ovf = 1; else m_depth++;
        m_cwp = (m_cwp + 1) % 4;
      end else if (ret && !call) begin
        if (m_depth == 0) m_unf = 1; else m_depth--;
        m_cwp = (m_cwp + 3) % 4;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then compare with the model
  task automatic drive(bit c, bit r, bit we, int wa, logic [31:0] wd, int a, int b);
    int pa, pb;
    @(negedge clk);
    call = c; ret = r; wen = we;
    waddr = 5'(wa); wdata = wd; ra = 5'(a); rb = 5'(b);
    #1;
    pa = lmap(a, m_cwp);
    pb = lmap(b, m_cwp);
    if (m_valid[pa]) chk("R3 read port A mapping", rda, m_regs[pa]);
    if (m_valid[pb]) chk("R3 read port B mapping", rdb, m_regs[pb]);
    chk("R6 window pointer", 32'(cwp), 32'(m_cwp));
    chk("R10 overflow flag", 32'(ovf), 32'(m_ovf));
    chk("R11 underflow flag", 32'(unf), 32'(m_unf));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; call = 0; ret = 0; wen = 0;
    #1;
    chk("R1 pointer during reset", 32'(cwp), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pointer after reset", 32'(cwp), 32'd0);
    chk("R1 overflow after reset", 32'(ovf), 32'd0);
    chk("R1 underflow after reset", 32'(unf), 32'd0);
  endtask

  initial begin
    logic [31:0] old;
    void'($urandom(32'd20240611));
    do_reset();

    // fill every physical register through the windows
    for (int w = 0; w < 4; w++) begin
      for (int n = (w == 0) ? 0 : 16; n < 32; n++)
        drive(0, 0, 1, n, $urandom, n, 31 - n);
      drive(1, 0, 0, 0, 0, 0, 0);
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    do_reset();

    // R8: same-cycle read sees the old value
    old = m_regs[20];
    drive(0, 0, 1, 20, 32'hA5A5_0001, 20, 20);
    chk("R8 read during write returns old", rda, old);
    drive(0, 0, 0, 0, 0, 20, 0);
    chk("R8 read after write returns new", rda, 32'hA5A5_0001);

    // R9: disabled write is ignored
    drive(0, 0, 0, 20, 32'hDEAD_BEEF, 20, 0);
    drive(0, 0, 0, 0, 0, 20, 0);
    chk("R9 disabled write ignored", rda, 32'hA5A5_0001);

    // R4: caller outgoing 28 is callee incoming 12
    drive(0, 0, 1, 28, 32'h1111_2828, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 12, 28);
    chk("R4 outgoing seen as incoming", rda, 32'h1111_2828);
    chk("R6 pointer after call", 32'(cwp), 32'd1);

    // R5: locals of window 1 do not touch window 0
    drive(0, 0, 1, 20, 32'hB0B0_0020, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 20, 0);
    chk("R5 caller local preserved", rda, 32'hA5A5_0001);
    chk("R6 pointer after return", 32'(cwp), 32'd0);
    chk("R11 no underflow at depth 1", 32'(unf), 32'd0);

    // R2: global visible from another window
    drive(0, 0, 1, 3, 32'h0303_0303, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 3, 0);
    chk("R2 global across windows", rda, 32'h0303_0303);

    // R7: both strobes cancel
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R7 pointer unchanged", 32'(cwp), 32'd1);
    chk("R7 no overflow", 32'(ovf), 32'd0);
    chk("R7 no underflow", 32'(unf), 32'd0);

    // R10: overflow at depth 3, wrap from window 3 to 0
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 27, 32'h0000_0027, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 11, 0);
    chk("R10 overflow pulse", 32'(ovf), 32'd1);
    chk("R10 pointer still wraps", 32'(cwp), 32'd0);
    chk("R4 wrap window 3 to 0", rda, 32'h0000_0027);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R10 overflow lasts one cycle", 32'(ovf), 32'd0);

    // R11: three returns to depth 0, then underflow
    repeat (3) drive(0, 1, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R11 underflow pulse", 32'(unf), 32'd1);
    chk("R11 pointer still steps back", 32'(cwp), 32'd0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R11 underflow lasts one cycle", 32'(unf), 32'd0);

    // constrained random traffic (R3, R5, R6, R10, R11)
    for (int k = 0; k < 3000; k++) begin
      bit c, r, we;
      c  = ($urandom % 6) == 0;
      r  = ($urandom % 6) == 0;
      we = ($urandom % 2) == 0;
      drive(c, r, we, int'($urandom % 32), $urandom,
            int'($urandom % 32), int'($urandom % 32));
    end
    drive(0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule